// File: doc/BRIEF.md
# Split Condition-Flag Status Register

This block holds the integer condition flags of a processor core as four separately stored groups: a two-bit negative/zero group, a carry bit, an overflow bit and a four-bit greater-or-equal group. Each group has its own write port and enable. An instruction that produces only some of the flags therefore writes only those groups, and the other groups keep their values. This removes false ordering dependencies between instructions that touch different flags. All bits of the status word that are not flags live in a separate base register.

Consumers see a single merged 32-bit status word, assembled every cycle from the base register and the four groups. A second output gives the same word filtered for a status-read instruction. A full 32-bit status write is split back into the base register and the groups. A floating-point flag transfer loads the negative/zero, carry and overflow groups from a separate four-bit input. Every write takes effect at the rising clock edge, and the outputs show the new state from that edge on.

Top module: `split_flag_status`

## Requirements
- R1: While rst_n is low at a rising edge, all flag groups clear to 0 and the base register loads BASE_RESET with bits 31:28 and 19:16 forced to 0. This reset takes priority over every write.
- R2: The merged word status_word holds N at bit 31, Z at bit 30, C at bit 29, V at bit 28 and the GE group at bits 19:16. Every other bit comes from the base register.
- R3: The NZ group is written through nz_wdata, with N in bit 1 and Z in bit 0. A write enabled by nz_we alone leaves C, V, GE and the base bits unchanged.
- R4: The C, V and GE groups are each written alone by c_we, v_we and ge_we. Each such write leaves every other group and the base bits unchanged.
- R5: A full write (word_we) loads bits 31:30, 29, 28 and 19:16 of word_wdata into the NZ, C, V and GE groups. It loads all remaining bits into the base register.
- R6: When a per-group enable and word_we are high in the same cycle, the enabled group takes its per-group data. Groups that are not enabled take the bits of word_wdata.
- R7: fpx_we loads fp_flags, ordered {n,z,c,v} in bits 3:0, into NZ as fp_flags[3:2], into C as fp_flags[1] and into V as fp_flags[0]. It leaves GE untouched. A per-group enable outweighs fpx_we for its group, and fpx_we outweighs word_we.
- R8: masked_word always equals status_word ANDed with 32'hF8FF03DF.
- R9: The base bits (all bits outside 31:28 and 19:16) change only on a full write or a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| nz_we | input | 1 | Write enable of the NZ group |
| nz_wdata | input | 2 | New NZ value, N in bit 1, Z in bit 0 |
| c_we | input | 1 | Write enable of the carry bit |
| c_wdata | input | 1 | New carry value |
| v_we | input | 1 | Write enable of the overflow bit |
| v_wdata | input | 1 | New overflow value |
| ge_we | input | 1 | Write enable of the GE group |
| ge_wdata | input | 4 | New GE value |
| fpx_we | input | 1 | Floating-point flag transfer enable |
| fp_flags | input | 4 | Floating-point flags {n,z,c,v} |
| word_we | input | 1 | Full status word write enable |
| word_wdata | input | 32 | Full status word value |
| status_word | output | 32 | Merged status view |
| masked_word | output | 32 | Merged view filtered for a status read |

## Verification
The hardest case to reach is three-way contention. A per-group write, a floating-point transfer and a full write all land in one cycle, and each group must pick its own winner. The difference only shows when the three sources carry different values for the same bit. The directed phase drives all three sources with distinct, complementary patterns, both with and without the per-group enables. A long pseudo-random phase then sets each enable independently, so every mix of partial and full updates occurs many times. A cycle-level reference model checks both outputs after every one of these updates.

// File: rtl/split_flag_status_pkg.sv
// Package: bit positions and masks of the merged status word.
// Assumes a 32-bit status word with the flag fields at fixed positions.
package split_flag_status_pkg;
    localparam int WORD_W    = 32;
    localparam int NZ_W      = 2;
    localparam int GE_W      = 4;
    localparam int FPF_W     = 4;
    localparam int NZ_LO     = 30;
    localparam int C_POS     = 29;
    localparam int V_POS     = 28;
    localparam int GE_LO     = 16;
    localparam int NZ_HI     = NZ_LO + NZ_W - 1;
    localparam int GE_HI     = GE_LO + GE_W - 1;
    localparam logic [WORD_W-1:0] FLAG_MASK = 32'hF00F0000;
    localparam logic [WORD_W-1:0] READ_MASK = 32'hF8FF03DF;
endpackage

// File: rtl/flag_field.sv
// Module: one flag group register with three prioritised write sources.
// Priority: own group port, then alternate source, then full-word split.
// Assumes synchronous active-low reset to zero.
module flag_field #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         grp_we,
    input  logic [W-1:0] grp_d,
    input  logic         alt_we,
    input  logic [W-1:0] alt_d,
    input  logic         word_we,
    input  logic [W-1:0] word_d,
    output logic [W-1:0] q
);
    // Select the value this group takes at the next edge.
    logic [W-1:0] nxt;
    always_comb begin
        if (grp_we)       nxt = grp_d;
        else if (alt_we)  nxt = alt_d;
        else if (word_we) nxt = word_d;
        else              nxt = q;
    end

    // Hold the group value; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= nxt;
    end
endmodule

// File: rtl/status_merge.sv
// Module: overlays the flag groups on the base register (combinational).
// Assumes the base register already holds zeros under the flag mask.
module status_merge
    import split_flag_status_pkg::*;
(
    input  logic [WORD_W-1:0] base,
    input  logic [NZ_W-1:0]   nz,
    input  logic              c,
    input  logic              v,
    input  logic [GE_W-1:0]   ge,
    output logic [WORD_W-1:0] merged,
    output logic [WORD_W-1:0] masked
);
    // Place each group at its field and filter for the read instruction.
    always_comb begin
        merged                = base & ~FLAG_MASK;
        merged[NZ_HI:NZ_LO]   = nz;
        merged[C_POS]         = c;
        merged[V_POS]         = v;
        merged[GE_HI:GE_LO]   = ge;
        masked                = merged & READ_MASK;
    end
endmodule

// File: rtl/split_flag_status.sv
// Module: status register with separately writable NZ, C, V and GE groups.
// Assumes single-cycle writes; no privilege or mode-change checking.
module split_flag_status
    import split_flag_status_pkg::*;
#(
    parameter logic [31:0] BASE_RESET = 32'h000001D3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        nz_we,
    input  logic [1:0]  nz_wdata,
    input  logic        c_we,
    input  logic        c_wdata,
    input  logic        v_we,
    input  logic        v_wdata,
    input  logic        ge_we,
    input  logic [3:0]  ge_wdata,
    input  logic        fpx_we,
    input  logic [3:0]  fp_flags,
    input  logic        word_we,
    input  logic [31:0] word_wdata,
    output logic [31:0] status_word,
    output logic [31:0] masked_word
);
    logic [WORD_W-1:0] base_q;
    logic [NZ_W-1:0]   nz_q;
    logic              c_q;
    logic              v_q;
    logic [GE_W-1:0]   ge_q;

    // Hold the non-flag bits; only a full write changes them.
    always_ff @(posedge clk) begin
        if (!rst_n)       base_q <= BASE_RESET & ~FLAG_MASK;
        else if (word_we) base_q <= word_wdata & ~FLAG_MASK;
    end

    flag_field #(.W(NZ_W)) u_nz (
        .clk, .rst_n,
        .grp_we(nz_we), .grp_d(nz_wdata),
        .alt_we(fpx_we), .alt_d(fp_flags[FPF_W-1:FPF_W-2]),
        .word_we, .word_d(word_wdata[NZ_HI:NZ_LO]),
        .q(nz_q)
    );

    flag_field #(.W(1)) u_c (
        .clk, .rst_n,
        .grp_we(c_we), .grp_d(c_wdata),
        .alt_we(fpx_we), .alt_d(fp_flags[1]),
        .word_we, .word_d(word_wdata[C_POS]),
        .q(c_q)
    );

    flag_field #(.W(1)) u_v (
        .clk, .rst_n,
        .grp_we(v_we), .grp_d(v_wdata),
        .alt_we(fpx_we), .alt_d(fp_flags[0]),
        .word_we, .word_d(word_wdata[V_POS]),
        .q(v_q)
    );

    flag_field #(.W(GE_W)) u_ge (
        .clk, .rst_n,
        .grp_we(ge_we), .grp_d(ge_wdata),
        .alt_we(1'b0), .alt_d('0),
        .word_we, .word_d(word_wdata[GE_HI:GE_LO]),
        .q(ge_q)
    );

    status_merge u_merge (
        .base(base_q), .nz(nz_q), .c(c_q), .v(v_q), .ge(ge_q),
        .merged(status_word), .masked(masked_word)
    );
endmodule

// File: rtl/split_flag_status_chk.sv
// Checker: temporal properties of split_flag_status, bound to every instance.
module split_flag_status_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        nz_we,
    input logic [1:0]  nz_wdata,
    input logic        c_we,
    input logic        c_wdata,
    input logic        v_we,
    input logic        v_wdata,
    input logic        ge_we,
    input logic [3:0]  ge_wdata,
    input logic        fpx_we,
    input logic [3:0]  fp_flags,
    input logic        word_we,
    input logic [31:0] word_wdata,
    input logic [31:0] status_word,
    input logic [31:0] masked_word
);
    a_r3_nz_group_write: assert property (@(posedge clk) disable iff (!rst_n)
        nz_we |=> status_word[31:30] == $past(nz_wdata));

    a_r4_c_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !c_we && !fpx_we && !word_we |=> $stable(status_word[29]));

    a_r4_ge_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ge_we && !word_we |=> $stable(status_word[19:16]));

    a_r6_word_split_ge: assert property (@(posedge clk) disable iff (!rst_n)
        word_we && !ge_we |=> status_word[19:16] == $past(word_wdata[19:16]));

    a_r7_fp_over_word: assert property (@(posedge clk) disable iff (!rst_n)
        fpx_we && !v_we |=> status_word[28] == $past(fp_flags[0]));

    a_r9_base_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !word_we |=> $stable(status_word & 32'h0FF0FFFF));

    a_r8_masked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_word & 32'h07000C20) == 32'h0);
endmodule

bind split_flag_status split_flag_status_chk u_chk (.*);

// File: tb/test_split_flag_status.sv
module test_split_flag_status;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] RST_VAL = 32'h000001D3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nz_we = 0, c_we = 0, v_we = 0, ge_we = 0, fpx_we = 0, word_we = 0;
    logic [1:0]  nz_wdata = 0;
    logic        c_wdata = 0, v_wdata = 0;
    logic [3:0]  ge_wdata = 0, fp_flags = 0;
    logic [31:0] word_wdata = 0;
    logic [31:0] status_word, masked_word;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_flag_status #(.BASE_RESET(RST_VAL)) i_split_flag_status (
        .clk, .rst_n, .nz_we, .nz_wdata, .c_we, .c_wdata, .v_we, .v_wdata,
        .ge_we, .ge_wdata, .fpx_we, .fp_flags, .word_we, .word_wdata,
        .status_word, .masked_word
    );

    // Reference state, kept behaviourally as plain integers.
    int m_n, m_z, m_c, m_v, m_ge;
    int unsigned m_base;
    int vectors = 0, fails = 0;
    string pend_tag = "R1";
    int unsigned lfsr = 32'h1234_5678;

    function automatic logic [31:0] expect_word();
        logic [31:0] w;
        w = m_base;
        w[31] = m_n[0]; w[30] = m_z[0]; w[29] = m_c[0]; w[28] = m_v[0];
        for (int i = 0; i < 4; i++) w[16+i] = m_ge[i];
        return w;
    endfunction

    task automatic compare();
        logic [31:0] e;
        e = expect_word();
        vectors++;
        if (status_word !== e) begin
            fails++;
            $display("FAIL %s status_word actual=%h expected=%h", pend_tag, status_word, e);
        end
        vectors++;
        if (masked_word !== (e & 32'hF8FF03DF)) begin
            fails++;
            $display("FAIL R8 masked_word actual=%h expected=%h", masked_word, e & 32'hF8FF03DF);
        end
    endtask

    // Model one clock edge from the currently driven inputs.
    task automatic model_step();
        if (!rst_n) begin
            m_n = 0; m_z = 0; m_c = 0; m_v = 0; m_ge = 0;
            m_base = RST_VAL & 32'h0FF0FFFF;
            return;
        end
        if (word_we) begin
            m_base = word_wdata & 32'h0FF0FFFF;
            m_n = word_wdata[31]; m_z = word_wdata[30];
            m_c = word_wdata[29]; m_v = word_wdata[28];
            m_ge = word_wdata[19:16];
        end
        if (fpx_we) begin
            m_n = fp_flags[3]; m_z = fp_flags[2]; m_c = fp_flags[1]; m_v = fp_flags[0];
        end
        if (nz_we) begin m_n = nz_wdata[1]; m_z = nz_wdata[0]; end
        if (c_we)  m_c = c_wdata;
        if (v_we)  m_v = v_wdata;
        if (ge_we) m_ge = ge_wdata;
    endtask

    // Compare the previous edge's result, then drive one new vector.
    task automatic apply(string tag, logic [5:0] en, logic [1:0] nzd, logic cd, logic vd,
                         logic [3:0] ged, logic [3:0] fpd, logic [31:0] wd);
        @(negedge clk);
        compare();
        {nz_we, c_we, v_we, ge_we, fpx_we, word_we} = en;
        nz_wdata = nzd; c_wdata = cd; v_wdata = vd; ge_wdata = ged;
        fp_flags = fpd; word_wdata = wd;
        model_step();
        pend_tag = tag;
    endtask

    function automatic int unsigned next_rand(int unsigned s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        rst_n = 0; word_we = 1; word_wdata = 32'hFFFFFFFF; nz_we = 1; nz_wdata = 2'b11;
        model_step();
        pend_tag = "R1";
        @(negedge clk);
        compare();                             // R1 reset state, writes ignored
        rst_n = 1;
        {nz_we, c_we, v_we, ge_we, fpx_we, word_we} = '0;
        // en order: nz c v ge fpx word
        apply("R1", 6'b000000, 2'b00, 0, 0, 4'h0, 4'h0, 32'h0);
        apply("R5", 6'b000001, 2'b00, 0, 0, 4'h0, 4'h0, 32'hA5A5A5A5);
        apply("R3", 6'b100000, 2'b10, 0, 0, 4'h0, 4'h0, 32'h0);
        apply("R3", 6'b100000, 2'b01, 0, 0, 4'h0, 4'h0, 32'h0);
        apply("R4", 6'b010000, 2'b00, 1, 0, 4'h0, 4'h0, 32'h0);
        apply("R4", 6'b001000, 2'b00, 0, 1, 4'h0, 4'h0, 32'h0);
        apply("R4", 6'b000100, 2'b00, 0, 0, 4'h9, 4'h0, 32'h0);
        apply("R9", 6'b111110, 2'b11, 0, 0, 4'h6, 4'hF, 32'hFFFFFFFF);
        apply("R5", 6'b000001, 2'b00, 0, 0, 4'h0, 4'h0, 32'h5F5A5A5A);
        apply("R6", 6'b100101, 2'b01, 0, 0, 4'h3, 4'h0, 32'hAFF5FFFF);
        apply("R6", 6'b011001, 2'b00, 0, 1, 4'h0, 4'h0, 32'hC00A0000);
        apply("R7", 6'b000010, 2'b00, 0, 0, 4'h0, 4'b1010, 32'h0);
        apply("R7", 6'b000011, 2'b00, 0, 0, 4'h0, 4'b0101, 32'hA00F1234);
        apply("R7", 6'b101011, 2'b10, 0, 0, 4'h0, 4'b0111, 32'h50000000);
        apply("R8", 6'b000001, 2'b00, 0, 0, 4'h0, 4'h0, 32'hFFFFFFFF);
        for (int k = 0; k < 2000; k++) begin
            int unsigned r1, r2;
            lfsr = next_rand(lfsr); r1 = lfsr;
            lfsr = next_rand(lfsr); r2 = lfsr;
            apply("R2", {r1[0], r1[3], r1[6], r1[9], r1[12], r1[15] & r1[16]},
                  r1[21:20], r1[22], r1[23], r1[27:24], r1[31:28], r2);
        end
        @(negedge clk);
        compare();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule